// File: doc/BRIEF.md
# Bidirectional GPIO Port with Gated Pullups

This block is an eight-pin general-purpose I/O port. Software reaches it through a small register bus. Each write is a single-cycle strobe, and each read is combinational. The port holds three per-pin registers:

- an output latch;
- a direction mask;
- a pullup-request mask.

For every pin the block drives an output value, an output enable and a pullup enable toward the pad. It also samples the pad level through a two-flop synchronizer.

A pin whose direction bit is set drives its latch bit, and its pullup is forced off for as long as it stays an output. A pin whose direction bit is clear is an input. It is either pulled up or left floating, according to its pullup-request bit. Reading the data register gives a per-bit mix: outputs report their latch bit and inputs report their synchronized pad level.

Top module: `gpio_port`

## Requirements
- R1: After reset the latch, direction and pullup-request registers all read 0x00, and every bit of `pin_oe` and `pin_pu` is 0.
- R2: The register offsets are: data at 0x0, direction at 0x4, pullup-request at 0x8. A write to the direction or pullup-request offset is read back unchanged from that offset on the next cycle.
- R3: A pin with direction bit 1 has `pin_oe` = 1 and `pin_out` equal to its latch bit.
- R4: A pin with direction bit 0 and pullup-request bit 1 has `pin_oe` = 0 and `pin_pu` = 1.
- R5: A pin with direction bit 0 and pullup-request bit 0 has `pin_oe` = 0 and `pin_pu` = 0.
- R6: A read of offset 0x0 returns, per bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R7: A write to offset 0x0 updates the latch for every bit, input bits included. Input bits keep `pin_oe` = 0, and the stored value appears on `pin_out` with `pin_oe` = 1 once that bit is made an output.
- R8: `pin_pu` is 0 in the first cycle after a write sets the bit's direction to 1. It returns to 1, with no rewrite of the pullup-request register, once the direction bit is cleared again.
- R9: A change on `pin_in` becomes visible in a data-register read after two rising clock edges, and not after one.
- R10: A read of any offset other than 0x0, 0x4 or 0x8 returns zero, and a write to such an offset changes no register.
- R11: Each register is written independently: a write to one offset leaves the other two registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| pin_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pullup enables |

## Verification
Two functions can meet in the same cycle: a latch write and the sampling of a changing pad input. The bench provokes this by driving a new `pin_in` pattern on the same cycle as a data-register write to a port with mixed directions. It judges the result with a data-register read two edges later. That read must show the new pad level on input bits and the written value on output bits, with no bleed between the two sources. A second overlap is also covered: a direction write whose effect on `pin_pu` and on the read source is sampled in the very next cycle.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NPINS  = 8;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_DATA = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_DIR  = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_PULL = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_DIR,
        SEL_PULL
    } regsel_e;

    typedef struct packed {
        logic [NPINS-1:0] latch;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pull;
    } portcfg_t;

    function automatic regsel_e decode_ofs(input logic [ADDR_W-1:0] a);
        regsel_e s;
        case (a)
            OFS_DATA: s = SEL_DATA;
            OFS_DIR:  s = SEL_DIR;
            OFS_PULL: s = SEL_PULL;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction

    // per-bit source choice for a data-register read
    function automatic logic [NPINS-1:0] mix_read(
        input logic [NPINS-1:0] dir,
        input logic [NPINS-1:0] latch,
        input logic [NPINS-1:0] pins
    );
        return (dir & latch) | (~dir & pins);
    endfunction

endpackage

// File: rtl/gpio_regbank.sv
module gpio_regbank
    import gpio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  regsel_e          sel,
    input  logic [NPINS-1:0] wdata,
    output portcfg_t         cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr) begin
            case (sel)
                SEL_DATA: cfg.latch <= wdata;
                SEL_DIR:  cfg.dir   <= wdata;
                SEL_PULL: cfg.pull  <= wdata;
                default:  ;
            endcase
        end
    end

    // R7
    latch_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_DATA) |=> cfg.latch == $past(wdata));

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_DIR) |=> cfg.dir == $past(wdata));

    // R10
    undef_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_NONE) |=> $stable(cfg));

    // R11
    other_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_PULL) |=> ($stable(cfg.latch) && $stable(cfg.dir)));

endmodule

// File: rtl/gpio_insync.sv
module gpio_insync
    import gpio_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pins_async,
    output logic [NPINS-1:0] pins_sync
);

    localparam int LAST = STAGES - 1;

    logic [NPINS-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= '0;
        else     chain[0] <= pins_async;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) chain[s] <= '0;
            else     chain[s] <= chain[s-1];
        end
    end

    assign pins_sync = chain[LAST];

    // R9
    sync_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> pins_sync == $past(chain[LAST-1]));

endmodule

// File: rtl/gpio_pinctl.sv
module gpio_pinctl
    import gpio_pkg::*;
(
    input  portcfg_t         cfg,
    output logic [NPINS-1:0] pin_out,
    output logic [NPINS-1:0] pin_oe,
    output logic [NPINS-1:0] pin_pu
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign pin_oe[i]  = cfg.dir[i];
        assign pin_out[i] = cfg.latch[i];
        // a pullup request only counts while the pin is an input
        assign pin_pu[i]  = cfg.pull[i] & ~cfg.dir[i];
    end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  pin_pu
);

    regsel_e          sel;
    portcfg_t         cfg;
    logic [NPINS-1:0] pins_sync;

    assign sel = decode_ofs(bus_addr);

    gpio_regbank u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (bus_wr),
        .sel   (sel),
        .wdata (bus_wdata),
        .cfg   (cfg)
    );

    gpio_insync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst        (rst),
        .pins_async (pin_in),
        .pins_sync  (pins_sync)
    );

    gpio_pinctl u_pins (
        .cfg     (cfg),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .pin_pu  (pin_pu)
    );

    always_comb begin
        case (sel)
            SEL_DATA: bus_rdata = mix_read(cfg.dir, cfg.latch, pins_sync);
            SEL_DIR:  bus_rdata = cfg.dir;
            SEL_PULL: bus_rdata = cfg.pull;
            default:  bus_rdata = '0;
        endcase
    end

    // R8
    pu_off_when_driven_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_oe & pin_pu) == '0);

    // R10
    undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE) |-> bus_rdata == '0);

    // R3
    out_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_DATA) |=> pin_out == $past(bus_wdata));

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] bus_addr;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;
    logic [7:0] pin_pu;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    gpio_port u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .pin_pu    (pin_pu)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Write on one edge; returns at the following negedge, after the update.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wr    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        pin_in = 8'hFF;
        do_reset();
        rd(4'h4, v); chk("R1 dir", v, 8'h00);
        rd(4'h8, v); chk("R1 pull", v, 8'h00);
        chk("R1 oe", pin_oe, 8'h00);
        chk("R1 pu", pin_pu, 8'h00);
        chk("R1 latch", pin_out, 8'h00);
    endtask

    task automatic t_regmap();
        logic [7:0] v;
        wr(4'h4, 8'h5A); rd(4'h4, v); chk("R2 dir readback", v, 8'h5A);
        wr(4'h8, 8'hC3); rd(4'h8, v); chk("R2 pull readback", v, 8'hC3);
        wr(4'h4, 8'h00); wr(4'h8, 8'h00);
    endtask

    task automatic t_output_mode();
        wr(4'h0, 8'hA5);
        wr(4'h4, 8'hFF);
        chk("R3 oe", pin_oe, 8'hFF);
        chk("R3 out", pin_out, 8'hA5);
        wr(4'h0, 8'h3C);
        chk("R3 out follows latch", pin_out, 8'h3C);
        wr(4'h4, 8'h00);
    endtask

    task automatic t_pull_modes();
        wr(4'h8, 8'hF0);
        chk("R4 pu on inputs", pin_pu, 8'hF0);
        chk("R4 oe off", pin_oe, 8'h00);
        chk("R5 floating bits", pin_pu & 8'h0F, 8'h00);
        wr(4'h8, 8'h00);
        chk("R5 all floating", pin_pu, 8'h00);
    endtask

    task automatic t_mixed_read();
        logic [7:0] v;
        pin_in = 8'h96;
        wr(4'h0, 8'h5C);
        wr(4'h4, 8'h0F);
        @(negedge clk);
        rd(4'h0, v);
        chk("R6 mixed read", v, (8'h0F & 8'h5C) | (8'hF0 & 8'h96));
        wr(4'h4, 8'h00);
    endtask

    task automatic t_latch_on_input();
        logic [7:0] v;
        pin_in = 8'h00;
        wr(4'h4, 8'h00);
        wr(4'h0, 8'hE7);
        chk("R7 oe stays off", pin_oe, 8'h00);
        @(negedge clk);
        rd(4'h0, v); chk("R7 input read shows pin", v, 8'h00);
        wr(4'h4, 8'hFF);
        chk("R7 stored value driven", pin_out, 8'hE7);
        chk("R7 oe after switch", pin_oe, 8'hFF);
        rd(4'h0, v); chk("R7 read latch", v, 8'hE7);
        wr(4'h4, 8'h00);
    endtask

    task automatic t_pull_gating();
        logic [7:0] v;
        wr(4'h8, 8'hFF);
        wr(4'h4, 8'h33);
        chk("R8 pu off next cycle", pin_pu, 8'hCC);
        wr(4'h4, 8'h00);
        chk("R8 pu returns", pin_pu, 8'hFF);
        rd(4'h8, v); chk("R8 pull kept", v, 8'hFF);
        wr(4'h8, 8'h00);
    endtask

    task automatic t_sync_latency();
        logic [7:0] v;
        wr(4'h4, 8'h00);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        pin_in = 8'h6B;
        @(negedge clk);
        rd(4'h0, v); chk("R9 one edge old", v, 8'h00);
        @(negedge clk);
        rd(4'h0, v); chk("R9 two edges new", v, 8'h6B);
    endtask

    // latch write on the same edge the pad changes; mixed directions
    task automatic t_overlap();
        logic [7:0] v;
        wr(4'h4, 8'hAA);
        pin_in = 8'h00;
        repeat (3) @(negedge clk);
        bus_addr  = 4'h0;
        bus_wr    = 1'b1;
        bus_wdata = 8'hF0;
        pin_in    = 8'h0F;
        @(negedge clk);
        bus_wr = 1'b0;
        @(negedge clk);
        rd(4'h0, v);
        chk("R6 overlap read", v, (8'hAA & 8'hF0) | (8'h55 & 8'h0F));
        wr(4'h4, 8'h00);
    endtask

    task automatic t_undefined();
        logic [7:0] v;
        wr(4'h0, 8'h11); wr(4'h4, 8'h22); wr(4'h8, 8'h44);
        wr(4'h2, 8'hFF); wr(4'hC, 8'hFF); wr(4'h5, 8'hFF);
        rd(4'h2, v); chk("R10 read undef", v, 8'h00);
        rd(4'hF, v); chk("R10 read undef hi", v, 8'h00);
        rd(4'h4, v); chk("R10 dir untouched", v, 8'h22);
        rd(4'h8, v); chk("R10 pull untouched", v, 8'h44);
        chk("R10 latch untouched", pin_out, 8'h11);
    endtask

    task automatic t_independence();
        logic [7:0] v;
        wr(4'h8, 8'h99);
        chk("R11 latch kept", pin_out, 8'h11);
        rd(4'h4, v); chk("R11 dir kept", v, 8'h22);
        wr(4'h0, 8'h77);
        rd(4'h8, v); chk("R11 pull kept", v, 8'h99);
        rd(4'h4, v); chk("R11 dir kept 2", v, 8'h22);
    endtask

    initial begin
        bus_addr  = 4'h0;
        bus_wr    = 1'b0;
        bus_wdata = 8'h00;
        pin_in    = 8'h00;
        rst       = 1'b1;
        t_reset();
        t_regmap();
        t_output_mode();
        t_pull_modes();
        t_mixed_read();
        t_latch_on_input();
        t_pull_gating();
        t_sync_latency();
        t_overlap();
        t_undefined();
        t_independence();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule